// File: doc/BRIEF.md
# Per-Core Interval Tick Timer

This block is the local event timer for a single processor core. A free-running prescaler divides the input clock into ticks, and a second down-counter counts those ticks to schedule interrupts. Software programs a prescale limit, an interval count and a small control word through a register window of 0x100 bytes. The timer then raises an interrupt either once (one-shot use) or repeatedly at a fixed period (interval mode, where the counter reloads itself).

The register port is a simple single-cycle write strobe plus a combinational read address. Every write is accepted on the clock edge at which `wr_en` is high; there is no back-pressure and no handshake, so the port is always ready. Each write to a buffer or to the control word leaves a sticky acknowledge bit that software can poll and then clear. A new interval count only reaches the running counter when the write asks for it explicitly, and then on the next tick, so software can retune the period without disturbing a count in progress.

Register offsets: 0x00 prescale limit, 0x08 interval buffer, 0x0C live interval count (read-only), 0x20 control, 0x30 interrupt status, 0x34 interrupt enable, 0x40 write acknowledge. Any other offset reads zero.

Top module: `ptick_core`

## Requirements
- R1: After reset every register offset reads zero and `irq` is low.
- R2: While control bit 0 is set, a tick occurs once every (L + 1) clock cycles, L being the value at 0x00; clearing bit 0 freezes the prescaler phase.
- R3: While control bit 1 is set, each tick decrements the live count (0x0C); the tick that takes it from 1 to 0 sets status bit 0 at 0x30.
- R4: With control bit 2 set, the tick that reaches zero reloads the count from the buffer (0x08, low 31 bits), giving an interrupt every N ticks; a zero buffer interrupts on every tick.
- R5: With control bit 2 clear, the count stays at zero after it expires and no further status is raised.
- R6: Clearing control bit 1 halts the interval counter, which keeps its value.
- R7: A write to 0x08 with bit 31 set marks an update pending (read back as bit 31 of 0x08); the next tick copies the buffer into the live count instead of counting and raises no status. A write with bit 31 clear changes only the buffer.
- R8: Writing 1 to bit 0 of 0x30 clears the status; a status raise in the same cycle wins. `irq` equals status AND enable (bit 0 of 0x34).
- R9: Writes to 0x00, 0x08 and 0x20 set acknowledge bits 0, 1 and 3 of 0x40; writing 1 to such a bit clears it, writing 0 leaves it.
- R10: Writes to 0x0C and to unused offsets change no state; unused offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, taken at the clock edge |
| wr_addr | input | 8 | Byte offset of the write inside the window |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Byte offset of the read |
| rd_data | output | 32 | Combinational read data for `rd_addr` |
| irq | output | 1 | Interrupt request, status AND enable |

## Verification
A wrong prescaler phase or interval count shows up as status and `irq` rising one or more cycles early or late, which the bench sees within one tick period because its model tracks the live count at 0x0C cycle by cycle. A stuck pending flag shows in bit 31 of 0x08 and as a count that fails to take the new value at the next tick. Faulty acknowledge or clear logic is exposed in the very next read of 0x40 or 0x30 after the write.

// File: rtl/ptick_pkg.sv
package ptick_pkg;

  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_TBUF = 8'h00;
  localparam logic [ADDR_W-1:0] A_IBUF = 8'h08;
  localparam logic [ADDR_W-1:0] A_ICUR = 8'h0C;
  localparam logic [ADDR_W-1:0] A_CTRL = 8'h20;
  localparam logic [ADDR_W-1:0] A_STAT = 8'h30;
  localparam logic [ADDR_W-1:0] A_IEN  = 8'h34;
  localparam logic [ADDR_W-1:0] A_WST  = 8'h40;

  localparam int W_TBUF = 0;
  localparam int W_IBUF = 1;
  localparam int W_CTRL = 3;
  localparam int WST_W  = 4;
  localparam int N_ACK  = 3;

  typedef struct packed {
    logic auto_reload;
    logic run_int;
    logic run_tick;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/ptick_prescale.sv
module ptick_prescale #(
  parameter int TICK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [TICK_W-1:0] limit,
  output logic              tick
);

  logic [TICK_W-1:0] phase_q;

  // >= keeps the divider safe when the limit is lowered below the phase
  assign tick = run && (phase_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (tick)    phase_q <= '0;
    else if (run)     phase_q <= phase_q + 1'b1;
  end

  // R2: a tick restarts the phase
  a_r2_phase_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (phase_q == '0));

  // R2: a stopped prescaler holds its phase
  a_r2_phase_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(phase_q));

endmodule

// File: rtl/ptick_interval.sv
module ptick_interval #(
  parameter int CNT_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             auto_reload,
  input  logic [CNT_W-1:0] reload,
  input  logic             upd_req,
  output logic             fire,
  output logic             pending,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;
  logic             take;
  logic             step;
  logic             expire;

  assign take   = tick && pend_q;
  assign step   = tick && run && !pend_q;
  assign expire = (cnt_q == ONE) || ((cnt_q == '0) && auto_reload);
  assign fire   = step && expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (take) begin
      cnt_q <= reload;
    end else if (step) begin
      if (cnt_q == '0) begin
        if (auto_reload) cnt_q <= reload;
      end else if (cnt_q == ONE) begin
        cnt_q <= auto_reload ? reload : '0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (upd_req) pend_q <= 1'b1;
    else if (take)    pend_q <= 1'b0;
  end

  assign pending = pend_q;
  assign count   = cnt_q;

  // R5: an expired one-shot count stays at zero
  a_r5_oneshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_reload && cnt_q == '0 && !take) |=> (cnt_q == '0));

  // R6: a halted counter keeps its value unless an update lands
  a_r6_halt_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !take) |=> $stable(cnt_q));

  // R7: a pending update copies the buffer on the tick
  a_r7_update_loads: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (cnt_q == $past(reload)));

  // R3: a one-shot expiry ends at zero
  a_r3_expire_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !auto_reload) |=> (cnt_q == '0));

endmodule

// File: rtl/ptick_regs.sv
module ptick_regs
  import ptick_pkg::*;
#(
  parameter int TICK_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              fire,
  input  logic              pending,
  input  logic [CNT_W-1:0]  count,
  output logic [TICK_W-1:0] tick_lim,
  output logic [CNT_W-1:0]  reload,
  output logic              upd_req,
  output ctrl_t             ctrl,
  output logic              irq
);

  logic [TICK_W-1:0] tbuf_q;
  logic [CNT_W-1:0]  ibuf_q;
  ctrl_t             ctrl_q;
  logic              stat_q;
  logic              ien_q;
  logic [N_ACK-1:0]  ack_q;
  logic [WST_W-1:0]  wst;

  function automatic logic hit(input logic [ADDR_W-1:0] a);
    return wr_en && (wr_addr == a);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbuf_q <= '0;
      ibuf_q <= '0;
      ctrl_q <= '0;
      ien_q  <= 1'b0;
    end else begin
      if (hit(A_TBUF)) tbuf_q <= wr_data[TICK_W-1:0];
      if (hit(A_IBUF)) ibuf_q <= wr_data[CNT_W-1:0];
      if (hit(A_CTRL)) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
      if (hit(A_IEN))  ien_q  <= wr_data[0];
    end
  end

  // status: a new expiry wins over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         stat_q <= 1'b0;
    else if (fire)                      stat_q <= 1'b1;
    else if (hit(A_STAT) && wr_data[0]) stat_q <= 1'b0;
  end

  for (genvar g = 0; g < N_ACK; g++) begin : g_ack
    localparam logic [ADDR_W-1:0] SRC = (g == 0) ? A_TBUF : (g == 1) ? A_IBUF : A_CTRL;
    localparam int                BIT = (g == 0) ? W_TBUF : (g == 1) ? W_IBUF : W_CTRL;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          ack_q[g] <= 1'b0;
      else if (hit(SRC))                   ack_q[g] <= 1'b1;
      else if (hit(A_WST) && wr_data[BIT]) ack_q[g] <= 1'b0;
    end

    // R9: a buffer or control write leaves its acknowledge set
    a_r9_ack_sets: assert property (@(posedge clk) disable iff (!rst_n)
      hit(SRC) |=> ack_q[g]);
  end

  always_comb begin
    wst         = '0;
    wst[W_TBUF] = ack_q[0];
    wst[W_IBUF] = ack_q[1];
    wst[W_CTRL] = ack_q[2];
  end

  always_comb begin
    unique case (rd_addr)
      A_TBUF:  rd_data = {{(DATA_W-TICK_W){1'b0}}, tbuf_q};
      A_IBUF:  rd_data = {pending, ibuf_q};
      A_ICUR:  rd_data = {1'b0, count};
      A_CTRL:  rd_data = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      A_STAT:  rd_data = {{(DATA_W-1){1'b0}}, stat_q};
      A_IEN:   rd_data = {{(DATA_W-1){1'b0}}, ien_q};
      A_WST:   rd_data = {{(DATA_W-WST_W){1'b0}}, wst};
      default: rd_data = '0;
    endcase
  end

  assign tick_lim = tbuf_q;
  assign reload   = ibuf_q;
  assign upd_req  = hit(A_IBUF) && wr_data[DATA_W-1];
  assign ctrl     = ctrl_q;
  assign irq      = stat_q && ien_q;

  // R3: an expiry is visible in the status on the next cycle
  a_r3_fire_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> stat_q);

  // R8: status drops only after a clear write
  a_r8_clear_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_q) |-> $past(hit(A_STAT) && wr_data[0]));

endmodule

// File: rtl/ptick_core.sv
module ptick_core
  import ptick_pkg::*;
#(
  parameter int TICK_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [7:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);

  localparam int CNT_W = DATA_W - 1;

  logic [TICK_W-1:0] tick_lim;
  logic [CNT_W-1:0]  reload;
  logic [CNT_W-1:0]  count;
  logic              upd_req;
  logic              tick;
  logic              fire;
  logic              pending;
  ctrl_t             ctrl;

  ptick_regs #(.TICK_W(TICK_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .fire     (fire),
    .pending  (pending),
    .count    (count),
    .tick_lim (tick_lim),
    .reload   (reload),
    .upd_req  (upd_req),
    .ctrl     (ctrl),
    .irq      (irq)
  );

  ptick_prescale #(.TICK_W(TICK_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (ctrl.run_tick),
    .limit (tick_lim),
    .tick  (tick)
  );

  ptick_interval #(.CNT_W(CNT_W)) u_int (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .run         (ctrl.run_int),
    .auto_reload (ctrl.auto_reload),
    .reload      (reload),
    .upd_req     (upd_req),
    .fire        (fire),
    .pending     (pending),
    .count       (count)
  );

  // R1: no interrupt request out of reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !irq);

endmodule

// File: tb/ptick_core_test.sv
module ptick_core_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;

  int total = 0;
  int bad   = 0;
  bit chk_on = 1'b0;

  always #10 clk = ~clk;

  ptick_core uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  // reference model built from the requirements
  logic [7:0]  m_pb, m_pc;
  logic [30:0] m_ib, m_cnt;
  logic        m_pend, m_stat, m_en;
  logic [2:0]  m_ctrl;
  logic [3:0]  m_wst;
  bit t, hitz, np, ns;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pb <= '0; m_pc <= '0; m_ib <= '0; m_cnt <= '0;
      m_pend <= 0; m_stat <= 0; m_en <= 0; m_ctrl <= '0; m_wst <= '0;
    end else begin
      t    = m_ctrl[0] && (m_pc >= m_pb);                              // R2
      hitz = t && m_ctrl[1] && !m_pend &&
             (m_cnt == 31'd1 || (m_cnt == 31'd0 && m_ctrl[2]));        // R3 R4
      if (t) m_pc <= '0; else if (m_ctrl[0]) m_pc <= m_pc + 8'd1;
      if (t && m_pend) m_cnt <= m_ib;                                   // R7
      else if (t && m_ctrl[1]) begin
        if (m_cnt == 0) begin if (m_ctrl[2]) m_cnt <= m_ib; end         // R5
        else if (m_cnt == 1) m_cnt <= m_ctrl[2] ? m_ib : 31'd0;
        else m_cnt <= m_cnt - 31'd1;
      end
      np = m_pend;
      if (t && m_pend) np = 0;
      if (wr_en && wr_addr == 8'h08 && wr_data[31]) np = 1;
      m_pend <= np;
      ns = m_stat;
      if (wr_en && wr_addr == 8'h30 && wr_data[0]) ns = 0;             // R8
      if (hitz) ns = 1;
      m_stat <= ns;
      if (wr_en) begin
        case (wr_addr)
          8'h00: begin m_pb <= wr_data[7:0];  m_wst[0] <= 1; end       // R9
          8'h08: begin m_ib <= wr_data[30:0]; m_wst[1] <= 1; end
          8'h20: begin m_ctrl <= wr_data[2:0]; m_wst[3] <= 1; end
          8'h34: m_en <= wr_data[0];
          8'h40: m_wst <= m_wst & ~(wr_data[3:0] & 4'b1011);
          default: ;                                                    // R10
        endcase
      end
    end
  end

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h00: return {24'h0, m_pb};
      8'h08: return {m_pend, m_ib};
      8'h0C: return {1'b0, m_cnt};
      8'h20: return {29'h0, m_ctrl};
      8'h30: return {31'h0, m_stat};
      8'h34: return {31'h0, m_en};
      8'h40: return {28'h0, m_wst};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h00: return "R2";
      8'h08: return "R7";
      8'h0C: return "R3";
      8'h20: return "R6";
      8'h30: return "R8";
      8'h34: return "R8";
      8'h40: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // continuous comparison against the model, away from the clock edge
  always @(negedge clk) begin
    if (chk_on) begin
      #2;
      chk(rd_data == exp_rd(rd_addr), tag_of(rd_addr), rd_data, exp_rd(rd_addr));
      chk(irq == (m_stat && m_en), "R8", {31'h0, irq}, {31'h0, m_stat && m_en});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    #2;
    d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] v, c1, c2;
    logic [7:0] alist [8] = '{8'h00, 8'h08, 8'h0C, 8'h10, 8'h20, 8'h30, 8'h34, 8'h40};
    int n;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    foreach (alist[i]) begin
      rd(alist[i], v);
      chk(v == 32'h0, "R1", v, 32'h0);
    end
    chk(irq == 1'b0, "R1", {31'h0, irq}, 32'h0);
    chk_on = 1'b1;

    // R4: periodic spacing = (L+1)*N cycles, here 2*3
    wr(8'h00, 32'd1);
    wr(8'h08, 32'h8000_0003);
    wr(8'h34, 32'd1);
    wr(8'h20, 32'd7);
    n = 0;
    do begin rd(8'h30, v); n++; end while (v[0] == 1'b0 && n < 200);
    wr_en = 1'b1; wr_addr = 8'h30; wr_data = 32'd1;
    chk(irq == 1'b1, "R8", {31'h0, irq}, 32'h1);
    n = 0;
    do begin
      @(negedge clk); wr_en = 1'b0; n++; #2;
    end while (rd_data[0] == 1'b0 && n < 200);
    chk(n == 6, "R4", n, 6);

    // R5: one-shot expires once and holds at zero
    wr(8'h20, 32'd0);
    wr(8'h30, 32'd1);
    wr(8'h08, 32'h8000_0002);
    wr(8'h20, 32'd3);
    idle(20);
    rd(8'h30, v); chk(v == 32'd1, "R5", v, 32'd1);
    wr(8'h30, 32'd1);
    idle(30);
    rd(8'h30, v); chk(v == 32'd0, "R5", v, 32'd0);
    rd(8'h0C, v); chk(v == 32'd0, "R5", v, 32'd0);

    // R6: halting the interval counter keeps its value
    wr(8'h00, 32'd3);
    wr(8'h08, 32'h8000_0007);
    wr(8'h20, 32'd7);
    idle(10);
    wr(8'h20, 32'd5);
    rd(8'h0C, c1);
    idle(15);
    rd(8'h0C, c2);
    chk(c1 == c2, "R6", c2, c1);

    // R7: buffer write without bit 31 leaves the live count alone
    wr(8'h20, 32'd0);
    rd(8'h0C, c1);
    wr(8'h08, 32'd5);
    wr(8'h20, 32'd1);
    idle(10);
    rd(8'h0C, c2); chk(c1 == c2, "R7", c2, c1);
    rd(8'h08, v);  chk(v == 32'd5, "R7", v, 32'd5);

    // R9: acknowledge set, write-0 keeps, write-1 clears
    wr(8'h40, 32'hF);
    wr(8'h00, 32'd2);
    rd(8'h40, v); chk(v == 32'h1, "R9", v, 32'h1);
    wr(8'h40, 32'h0);
    rd(8'h40, v); chk(v == 32'h1, "R9", v, 32'h1);
    wr(8'h40, 32'h1);
    rd(8'h40, v); chk(v == 32'h0, "R9", v, 32'h0);

    // R10: unused and read-only offsets
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, v); chk(v == 32'h0, "R10", v, 32'h0);
    rd(8'h0C, c1);
    wr(8'h0C, 32'h1234);
    rd(8'h0C, c2); chk(c1 == c2, "R10", c2, c1);

    // constrained random traffic checked by the model every cycle
    for (int i = 0; i < 12000; i++) begin
      @(negedge clk);
      rd_addr = alist[$urandom % 8];
      if (($urandom % 4) == 0) begin
        logic [31:0] r;
        logic [7:0]  a;
        r = $urandom;
        a = alist[$urandom % 8];
        case (a)
          8'h00: r = r & 32'h3;
          8'h08: r = r & 32'h8000_0007;
          8'h20: r = ((r % 5) != 0) ? ((r | 32'h3) & 32'h7) : (r & 32'h7);
          default: ;
        endcase
        wr_en = 1'b1; wr_addr = a; wr_data = r;
      end else begin
        wr_en = 1'b0;
      end
    end
    @(negedge clk);
    wr_en = 1'b0;
    idle(4);
    chk_on = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule